// File: doc/BRIEF.md
# Pipelined Burst Static RAM Core

This block is a single-port synchronous static RAM with a register-held array (256 words of 36 bits by default, split into four 9-bit byte lanes), a two-bit burst sequencer and a registered read path. Address, strobes, advance, selects and write controls are all captured on the rising clock edge. A burst opens on a start edge raised by either the processor-side strobe or the controller-side strobe, provided all three chip selects are active. Later edges without a start strobe either step the burst (advance low) or repeat the current word (advance high). Each of those edges is a read or a write according to the write controls.

Read data comes back through an output register and a drive flag, `rdata_drive`, which stands in for a tri-state pad. The output enable and the sleep input act on this flag at once, without a clock edge. A sampled write turns the flag off for the following cycle. Sleep freezes the array and the burst state. After sleep falls, start strobes are ignored on two edges.

The interface is a fixed-latency pin protocol and has no valid/ready handshake. The block never applies back-pressure. Every edge is accepted or ignored by the rules below, and read results appear at a fixed cycle whether or not anyone consumes them.

Top module: `pbsram_core`

## Requirements
- R1: A start edge is one where `strobe_proc_n` is low with `sel_a_n` low, or `strobe_ctrl_n` is low otherwise. A burst begins only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 on that edge; otherwise the start edge deselects. A low `strobe_proc_n` with `sel_a_n` high is ignored, so a running burst continues.
- R2: A start through `strobe_proc_n` is always a read, whatever the write controls.
- R3: A start through `strobe_ctrl_n` (with `strobe_proc_n` high) samples the write controls on that same edge.
- R4: `glob_wr_n`=0 writes all lanes. With `glob_wr_n`=1 and `byte_wr_n`=0, each low bit i of `lane_wr_n` writes data bits [9i+8:9i]. With both high, the edge is a read.
- R5: A read whose address is sampled on edge N shows the addressed word on `rdata` with `rdata_drive`=1 after edge N+1.
- R6: On a non-start edge of a selected burst, `advance_n`=0 moves to the next burst word and `advance_n`=1 repeats the current one. The sequence wraps after four words and keeps the upper address bits.
- R7: The two low address bits follow (start + k) mod 4 when `order_interleave`=0, and start XOR k when it is 1, for step k.
- R8: In the cycle after an edge that samples a write, `rdata_drive` is 0, whatever `out_en_n` is.
- R9: `out_en_n`=1 forces `rdata_drive` to 0 without a clock edge; returning it low restores the flag in the same cycle.
- R10: `sleep`=1 forces `rdata_drive` to 0 at once. Edges sampled during sleep perform no read or write, and the array contents are kept.
- R11: The two edges after `sleep` is last sampled high perform no access; the third edge is accepted.
- R12: After a deselecting start edge, the read from the edge before still shows. The flag is 0 from the following cycle on.
- R13: While and after reset, with no start edge, `rdata_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Word address, sampled on start edges |
| strobe_proc_n | input | 1 | Processor-side start strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| glob_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Enables per-lane writes, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| wdata | input | 36 | Write data, sampled on the write edge |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| order_interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static level) |
| sleep | input | 1 | Power-down request, active high |
| rdata | output | 36 | Output register contents |
| rdata_drive | output | 1 | High when the bus would be driven with `rdata` |

## Verification
A read sampled on edge N is due after edge N+1. The bench drives each operation just after a rising edge and predicts the bus on the falling edge that follows the second rising edge after that point, so each expected item carries a due index three falling edges ahead. A write hides the read issued one cycle earlier, so the driver clears the drive expectation of that queued item. Output enable and sleep need no edge, so their checks sample one time unit after the input changes, between falling edges, where the monitor never looks.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  localparam int BURST_LEN = 4;
  localparam int SEQ_W     = $clog2(BURST_LEN);

  // Next low address bits of a burst for step k
  function automatic logic [SEQ_W-1:0] burst_lo(input logic [SEQ_W-1:0] start,
                                                input logic [SEQ_W-1:0] k,
                                                input logic             xor_order);
    return xor_order ? (start ^ k) : (start + k);
  endfunction
endpackage

// File: rtl/pbsram_burst.sv
module pbsram_burst
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              commit,
  input  logic              xor_order,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] op_addr
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [SEQ_W-1:0]  k_q, k_n;

  always_comb begin
    base_n = load ? ext_addr : base_q;
    if (load)      k_n = '0;
    else if (step) k_n = k_q + 1'b1;
    else           k_n = k_q;
    op_addr = {base_n[ADDR_W-1:SEQ_W], burst_lo(base_n[SEQ_W-1:0], k_n, xor_order)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      k_q    <= '0;
    end else if (commit) begin
      base_q <= base_n;
      k_q    <= k_n;
    end
  end
endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl #(
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_proc_n,
  input  logic             strobe_ctrl_n,
  input  logic             advance_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             glob_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             sleep,
  output logic             load,
  output logic             step,
  output logic             commit,
  output logic             rd_stage,
  output logic             wr_stage,
  output logic [LANES-1:0] lanes_stage,
  output logic             wake_busy
);
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  logic              selected_q;
  logic [WAKE_W-1:0] wake_q;
  logic              blocked, cs_ok, proc_edge, ctrl_edge, start_edge;
  logic              begin_op, desel, cont, wr_req, is_wr, is_rd;
  logic [LANES-1:0]  lanes;

  assign wake_busy = (wake_q != '0);

  always_comb begin
    blocked    = sleep | wake_busy;
    cs_ok      = !sel_a_n && sel_b && !sel_c_n;
    proc_edge  = !strobe_proc_n && !sel_a_n;
    ctrl_edge  = !strobe_ctrl_n && !proc_edge;
    start_edge = proc_edge || ctrl_edge;
    begin_op   = start_edge && cs_ok && !blocked;
    desel      = start_edge && !cs_ok && !blocked;
    cont       = !start_edge && selected_q && !blocked;
    if (!glob_wr_n)     lanes = '1;
    else if (!byte_wr_n) lanes = ~lane_wr_n;
    else                lanes = '0;
    wr_req = |lanes;
    // processor-strobe starts never write
    is_wr  = (begin_op && !proc_edge && wr_req) || (cont && wr_req);
    is_rd  = (begin_op || cont) && !is_wr;
    load   = begin_op;
    step   = cont && !advance_n;
    commit = begin_op || cont;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected_q  <= 1'b0;
      wake_q      <= '0;
      rd_stage    <= 1'b0;
      wr_stage    <= 1'b0;
      lanes_stage <= '0;
    end else begin
      if (begin_op)   selected_q <= 1'b1;
      else if (desel) selected_q <= 1'b0;
      if (sleep)          wake_q <= WAKE_W'(WAKE_CYC);
      else if (wake_busy) wake_q <= wake_q - 1'b1;
      rd_stage    <= is_rd;
      wr_stage    <= is_wr;
      lanes_stage <= is_wr ? lanes : '0;
    end
  end
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[g]) mem[addr] <= wr_data[g*LANE_W +: LANE_W];
      if (rd_en) rd_q <= mem[addr];
    end
    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/pbsram_outstage.sv
module pbsram_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stage,
  input  logic wr_stage,
  input  logic out_en_n,
  input  logic sleep,
  output logic drive
);
  logic dvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dvalid_q <= 1'b0;
    else        dvalid_q <= rd_stage;
  end

  // enable and sleep act without a clock edge
  assign drive = dvalid_q && !wr_stage && !out_en_n && !sleep;
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core #(
  parameter int ADDR_W   = 8,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobe_proc_n,
  input  logic                    strobe_ctrl_n,
  input  logic                    advance_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    glob_wr_n,
  input  logic                    byte_wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  input  logic                    order_interleave,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              load, step, commit, rd_stage, wr_stage, wake_busy;
  logic [LANES-1:0]  lanes_stage;
  logic [ADDR_W-1:0] op_addr, addr_q;
  logic [DATA_W-1:0] wdata_q;

  pbsram_ctrl #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe_proc_n(strobe_proc_n),
    .strobe_ctrl_n(strobe_ctrl_n), .advance_n(advance_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .glob_wr_n(glob_wr_n),
    .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n), .sleep(sleep),
    .load(load), .step(step), .commit(commit), .rd_stage(rd_stage),
    .wr_stage(wr_stage), .lanes_stage(lanes_stage), .wake_busy(wake_busy)
  );

  pbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .commit(commit),
    .xor_order(order_interleave), .ext_addr(addr), .op_addr(op_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (commit) addr_q <= op_addr;
      wdata_q <= wdata;
    end
  end

  pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rd_en(rd_stage), .wr_en(wr_stage), .wr_lanes(lanes_stage),
    .addr(addr_q), .wr_data(wdata_q), .rd_data(rdata)
  );

  pbsram_outstage u_out (
    .clk(clk), .rst_n(rst_n), .rd_stage(rd_stage), .wr_stage(wr_stage),
    .out_en_n(out_en_n), .sleep(sleep), .drive(rdata_drive)
  );
endmodule

// File: rtl/pbsram_core_chk.sv
module pbsram_core_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe_proc_n,
  input logic strobe_ctrl_n,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n,
  input logic out_en_n,
  input logic sleep,
  input logic rdata_drive,
  input logic rd_stage,
  input logic wr_stage,
  input logic wake_busy
);
  p_proc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_proc_n && !sel_a_n && sel_b && !sel_c_n) |=> !wr_stage);

  p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stage && wr_stage));

  p_write_hides_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stage |-> !rdata_drive);

  p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_drive);

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_drive);

  p_wake_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || wake_busy) |=> (!rd_stage && !wr_stage));

  p_drain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_ctrl_n && strobe_proc_n && sel_a_n && !sleep && !wake_busy)
      |=> ##1 !rdata_drive);
endmodule

bind pbsram_core pbsram_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_proc_n(strobe_proc_n),
  .strobe_ctrl_n(strobe_ctrl_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .out_en_n(out_en_n), .sleep(sleep),
  .rdata_drive(rdata_drive), .rd_stage(rd_stage), .wr_stage(wr_stage),
  .wake_busy(wake_busy)
);

// File: tb/tb_pbsram_core.sv
module tb_pbsram_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        proc_n, ctrl_n, adv_n, sa_n, sb, sc_n, gw_n, bw_n;
  logic [3:0]  lane_n;
  logic [35:0] wdata = '0;
  logic        oe_n = 1'b0, ilv = 1'b0, slp = 1'b0;
  logic [35:0] rdata;
  logic        rdata_drive;

  pbsram_core dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_proc_n(proc_n),
    .strobe_ctrl_n(ctrl_n), .advance_n(adv_n), .sel_a_n(sa_n), .sel_b(sb),
    .sel_c_n(sc_n), .glob_wr_n(gw_n), .byte_wr_n(bw_n), .lane_wr_n(lane_n),
    .wdata(wdata), .out_en_n(oe_n), .order_interleave(ilv), .sleep(slp),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    bit          drv;
    logic [35:0] data;
    string       req;
  } exp_t;

  exp_t        q[$];
  exp_t        e;
  int          ncyc = 0, n_chk = 0, n_err = 0;
  bit          track = 1'b1, done = 1'b0;
  logic [35:0] model [256];
  logic [7:0]  bb_base;
  logic [1:0]  bb_k;

  function automatic logic [35:0] pat(input logic [7:0] a);
    return {a[3:0], a, a ^ 8'hA5, 8'(a * 3), ~a};
  endfunction

  function automatic logic [7:0] cur_addr();
    logic [1:0] lo;
    lo = ilv ? (bb_base[1:0] ^ bb_k) : (bb_base[1:0] + bb_k);
    return {bb_base[7:2], lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [36:0] act,
                       input logic [36:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares the bus with queued expectations on falling edges
  always @(negedge clk) begin
    ncyc++;
    while (q.size() > 0 && q[0].due <= ncyc) begin
      e = q.pop_front();
      check(rdata_drive === e.drv && (!e.drv || rdata === e.data), e.req,
            {rdata_drive, rdata}, {e.drv, e.data});
    end
  end

  task automatic push(input bit drv, input logic [35:0] d, input string req);
    if (track) q.push_back('{ncyc + 3, drv, d, req});
  endtask

  task automatic hide_prev();
    if (track && q.size() > 0 && q[q.size()-1].due == ncyc + 2)
      q[q.size()-1].drv = 1'b0;
  endtask

  task automatic mwrite(input logic [7:0] a, input logic g, input logic b,
                        input logic [3:0] ln, input logic [35:0] d);
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !ln[i])) model[a][i*9 +: 9] = d[i*9 +: 9];
  endtask

  task automatic set_idle();
    proc_n = 1; ctrl_n = 1; adv_n = 1; sa_n = 0; sb = 1; sc_n = 0;
    gw_n = 1; bw_n = 1; lane_n = '1;
  endtask

  task automatic go();
    @(posedge clk); #2;
  endtask

  task automatic t_desel();
    go(); set_idle(); ctrl_n = 0; sa_n = 1;
    push(0, '0, "R12");
  endtask

  task automatic t_read_start(input logic [7:0] a, input bit use_ctrl,
                              input string req);
    go(); set_idle(); addr = a;
    if (use_ctrl) ctrl_n = 0; else proc_n = 0;
    bb_base = a; bb_k = 0;
    push(1, model[a], req);
  endtask

  task automatic t_write_start(input logic [7:0] a, input logic g, input logic b,
                               input logic [3:0] ln, input logic [35:0] d,
                               input string req);
    go(); set_idle(); addr = a; ctrl_n = 0; gw_n = g; bw_n = b; lane_n = ln;
    wdata = d; bb_base = a; bb_k = 0;
    hide_prev(); mwrite(a, g, b, ln, d);
    push(0, '0, req);
  endtask

  task automatic t_cont(input bit advance, input bit wr, input logic g,
                        input logic b, input logic [3:0] ln, input logic [35:0] d,
                        input string req);
    logic [7:0] a;
    go(); set_idle(); adv_n = !advance;
    if (advance) bb_k = bb_k + 1'b1;
    a = cur_addr();
    if (wr) begin
      gw_n = g; bw_n = b; lane_n = ln; wdata = d;
      hide_prev(); mwrite(a, g, b, ln, d);
      push(0, '0, req);
    end else begin
      push(1, model[a], req);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    set_idle();
    for (int i = 0; i < 256; i++) model[i] = 'x;
    repeat (3) @(posedge clk);
    #2 check(rdata_drive === 1'b0, "R13", {36'd0, rdata_drive}, 37'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata_drive === 1'b0, "R13", {36'd0, rdata_drive}, 37'd0);

    // fill two bursts with full writes through the controller strobe (R3, R4)
    for (int b = 0; b < 2; b++) begin
      logic [7:0] base;
      base = (b == 0) ? 8'h10 : 8'h20;
      t_write_start(base, 0, 1, '1, pat(base), "R3");
      for (int j = 1; j < 4; j++) t_cont(1, 1, 0, 1, '1, pat(base + 8'(j)), "R4");
    end
    t_desel();

    // linear order with wrap, then suspend (R5, R6, R7)
    t_read_start(8'h11, 0, "R5");
    t_cont(1, 0, 1, 1, '1, '0, "R7");
    t_cont(1, 0, 1, 1, '1, '0, "R7");
    t_cont(1, 0, 1, 1, '1, '0, "R6");
    t_cont(0, 0, 1, 1, '1, '0, "R6");
    t_desel();

    // interleaved order (R7)
    ilv = 1'b1;
    t_read_start(8'h21, 0, "R7");
    for (int j = 0; j < 3; j++) t_cont(1, 0, 1, 1, '1, '0, "R7");
    t_desel();
    drain();
    ilv = 1'b0;

    // lane write of lanes 0 and 2, then read with both write controls high (R4, R8)
    t_write_start(8'h12, 1, 0, 4'b1010, 36'h1_2345_6789, "R4");
    t_cont(0, 0, 1, 1, '1, '0, "R4");
    t_desel();

    // processor start ignores a low global write (R2)
    go(); set_idle(); addr = 8'h13; proc_n = 0; gw_n = 0; wdata = '0;
    bb_base = 8'h13; bb_k = 0;
    push(1, model[8'h13], "R2");
    t_cont(0, 0, 1, 1, '1, '0, "R2");
    t_desel();

    // controller start as a read, then a write in mid burst hides the prior read (R3, R8)
    t_read_start(8'h10, 1, "R3");
    t_cont(1, 1, 0, 1, '1, 36'hA_BCDE_F012, "R8");
    t_cont(1, 0, 1, 1, '1, '0, "R8");
    t_desel();

    // selects (R1)
    go(); set_idle(); addr = 8'h10; proc_n = 0; sa_n = 1; push(0, '0, "R1");
    go(); set_idle(); addr = 8'h10; proc_n = 0; sb = 0;   push(0, '0, "R1");
    go(); set_idle(); addr = 8'h10; ctrl_n = 0; sc_n = 1; push(0, '0, "R1");
    t_read_start(8'h20, 0, "R1");
    go(); set_idle(); proc_n = 0; sa_n = 1; adv_n = 0; addr = 8'h00;
    bb_k = bb_k + 1'b1; push(1, model[cur_addr()], "R1");
    t_desel();
    drain();

    // asynchronous enable and sleep (R5, R9, R10)
    track = 1'b0;
    t_read_start(8'h13, 0, "R5");
    for (int j = 0; j < 3; j++) t_cont(0, 0, 1, 1, '1, '0, "R5");
    check(rdata_drive === 1'b1 && rdata === model[8'h13], "R5",
          {rdata_drive, rdata}, {1'b1, model[8'h13]});
    oe_n = 1'b1; #1;
    check(rdata_drive === 1'b0, "R9", {36'd0, rdata_drive}, 37'd0);
    oe_n = 1'b0; #1;
    check(rdata_drive === 1'b1, "R9", {36'd0, rdata_drive}, 37'd1);
    slp = 1'b1; #1;
    check(rdata_drive === 1'b0, "R10", {36'd0, rdata_drive}, 37'd0);
    for (int j = 0; j < 3; j++) begin
      go(); set_idle(); addr = 8'h13; ctrl_n = 0; gw_n = 0; wdata = '0;
    end
    go(); set_idle();
    @(negedge clk);
    check(rdata_drive === 1'b0, "R10", {36'd0, rdata_drive}, 37'd0);

    // wake-up window (R11), then contents kept (R10)
    track = 1'b1;
    go(); slp = 1'b0; set_idle(); addr = 8'h10; ctrl_n = 0; push(0, '0, "R11");
    go(); set_idle(); addr = 8'h10; ctrl_n = 0; push(0, '0, "R11");
    t_read_start(8'h13, 0, "R10");
    t_cont(0, 0, 1, 1, '1, '0, "R11");
    t_desel();
    t_desel();
    drain();
    finish_run();
  end
endmodule